// File: doc/BRIEF.md
# System Control Register Bank

This block is a memory-mapped set of 32-bit general-purpose registers for a small SoC. It answers a simple select/write-enable bus that carries a 12-bit byte address, so it decodes a 4 KiB window. Software writes words into it and reads them back. Four identification words hold preset values after reset. Three status locations always read with two fixed flag bits set.

Only the lower half of the window has storage behind it. Writes to the upper half change nothing, and reads there return zero. One location in the upper half is a power-control command. Writing a recognised code there produces a single-cycle request pulse on the reset-request output or on the shutdown-request output. The value written is not kept anywhere.

Each cycle in which select is high is one complete transfer. There are no wait states and no error response. Byte enables are not supported; every access is a full word.

Top module: `sysctl_regbank`

## Requirements
- R1: After a synchronous active-low reset, word index 0x40 holds 0x05F20121, 0x41 holds 0x00000002, 0x42 holds 0x05F30121 and 0x43 holds 0x05F40121. Every other stored word holds zero. Both request outputs are low.
- R2: A write with select and write enable high stores the write data at word index address[11:2], for every index from 0 to 511. A read with select high and write enable low presents that word on the read data port one clock later. The read data port holds its value in cycles without a read.
- R3: A write at a byte offset of 0x800 or above changes no stored word.
- R4: A read at a byte offset of 0x800 or above returns zero.
- R5: Reads at byte offsets 0x100, 0x108 and 0x10C (word indices 0x40, 0x42 and 0x43) return the stored word OR 0x30000000. The stored word itself is not modified. Reads at any other offset are not modified either.
- R6: A write to byte offset 0xF00 with data 1 or 2 raises the reset-request output for exactly the one cycle after the write. Data 3 raises the shutdown-request output in the same way. Any other data value raises neither output. The two outputs are never high together.
- R7: A command write is not stored. A later read at offset 0xF00 returns zero, and the backed words are unchanged.
- R8: Address bits [1:0] are ignored, so an unaligned offset selects the word that contains it. This applies to storage, to the status merge and to the command decode.
- R9: A read at offset 0xF00 produces no request pulse, whatever value is on the write data lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Transfer select; each high cycle is one transfer |
| pwrite | input | 1 | High for a write, low for a read |
| paddr | input | 12 | Byte address within the 4 KiB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data, valid one cycle after a read |
| reset_req | output | 1 | One-cycle system reset request pulse |
| shutdown_req | output | 1 | One-cycle shutdown request pulse |

## Verification
The bench builds the bank with its default parameters: a 12-bit address, 512 stored words, and the command at offset 0xF00. With these values every backed word can be written and read back in a single pass. The whole unbacked upper half, including the command location, can be reached in the same run. This lets the bench sweep the boundary at 0x800, walk command codes 0 to 4, and confirm that the identification and status words sit inside the backed range.

// File: rtl/sysctl_pkg.sv
// Shared types and constants for the system control register bank.
// Assumes 32-bit words; the identification and status indices are fixed.
package sysctl_pkg;

    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Flag bits merged into status reads
    localparam word_t STATUS_FORCE = 32'h3000_0000;

    // Decoded power command
    typedef enum logic [1:0] {
        REQ_NONE     = 2'd0,
        REQ_RESET    = 2'd1,
        REQ_SHUTDOWN = 2'd2
    } power_req_e;

    // Map a command data value to a request kind
    function automatic power_req_e decode_cmd(word_t v);
        case (v)
            32'd1, 32'd2: return REQ_RESET;
            32'd3:        return REQ_SHUTDOWN;
            default:      return REQ_NONE;
        endcase
    endfunction

    // Reset contents of a stored word, by word index
    function automatic word_t reset_word(int unsigned idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return '0;
        endcase
    endfunction

    // True for word indices whose reads carry the forced flags
    function automatic logic is_status_word(int unsigned idx);
        return (idx == 32'h40) || (idx == 32'h42) || (idx == 32'h43);
    endfunction

endpackage

// File: rtl/sysctl_store.sv
// Backing storage: NUM_WORDS words, with preset values loaded on reset.
// Writes outside the backed range are dropped; reads there give zero.
// Assumes the index is the byte address with the low two bits removed.
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned NUM_WORDS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_in_range,
    output word_t            rd_word
);

    localparam int unsigned STORE_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_WORDS);

    logic [NUM_WORDS-1:0][WORD_W-1:0] mem_q;
    logic wr_in_range;

    // Range checks on both access paths
    assign wr_in_range = {1'b0, wr_idx} < LIMIT;
    assign rd_in_range = {1'b0, rd_idx} < LIMIT;

    // Storage update: preset on reset, keep in-range writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int unsigned i = 0; i < NUM_WORDS; i++) begin
                mem_q[i] <= reset_word(i);
            end
        end else if (wr_en && wr_in_range) begin
            mem_q[wr_idx[STORE_W-1:0]] <= wr_data;
        end
    end

    // Word lookup for reads, zero outside the backed range
    always_comb begin
        rd_word = '0;
        if (rd_in_range) begin
            rd_word = mem_q[rd_idx[STORE_W-1:0]];
        end
    end

    AST_HIGH_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_in_range) |=> $stable(mem_q)); // R3

endmodule

// File: rtl/sysctl_rd_path.sv
// Read path: merges the status flags into chosen words and registers the result.
// Assumes the storage returns zero for out-of-range indices.
module sysctl_rd_path
    import sysctl_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_in_range,
    input  word_t            rd_word,
    output word_t            rdata
);

    word_t merged;

    // Force the status flags on the selected indices
    always_comb begin
        merged = rd_word;
        if (rd_in_range && is_status_word(int'(rd_idx))) begin
            merged = rd_word | STATUS_FORCE;
        end
    end

    // Read data register, updated only on reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= merged;
        end
    end

    AST_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_in_range) |=> (rdata == '0)); // R4
    AST_STATUS_FLAGS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_in_range && is_status_word(int'(rd_idx)))
        |=> ((rdata & STATUS_FORCE) == STATUS_FORCE)); // R5
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R2

endmodule

// File: rtl/sysctl_cmd_decode.sv
// Power command decode: a write to the command index yields a one-cycle
// registered request pulse. Assumes each select cycle is one transfer.
module sysctl_cmd_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned IDX_W   = 10,
    parameter int unsigned CMD_IDX = 32'h3C0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    output logic             reset_req,
    output logic             shutdown_req
);

    power_req_e req_q;
    logic       cmd_hit;

    // Detect a write aimed at the command location
    assign cmd_hit = wr_en && (wr_idx == IDX_W'(CMD_IDX));

    // Request register, cleared unless a command write arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= REQ_NONE;
        end else if (cmd_hit) begin
            req_q <= decode_cmd(wr_data);
        end else begin
            req_q <= REQ_NONE;
        end
    end

    // Drive the request outputs from the registered state
    assign reset_req    = (req_q == REQ_RESET);
    assign shutdown_req = (req_q == REQ_SHUTDOWN);

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reset_req, shutdown_req})); // R6

endmodule

// File: rtl/sysctl_regbank.sv
// System control register bank top. Decodes a 4 KiB window into word
// indices, feeds storage, status read merge and power command decode.
// Assumes one transfer per select cycle, word accesses, no wait states.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_WORDS  = 512,
    parameter int unsigned CMD_OFFSET = 32'hF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              reset_req,
    output logic              shutdown_req
);

    localparam int unsigned IDX_W   = ADDR_W - 2;
    localparam int unsigned CMD_IDX = CMD_OFFSET >> 2;

    logic [IDX_W-1:0] word_idx;
    logic             wr_en;
    logic             rd_en;
    logic             rd_in_range;
    word_t            rd_word;
    logic             addr_lo_unused;

    // Transfer qualification and word indexing
    assign word_idx       = paddr[ADDR_W-1:2];
    assign wr_en          = psel && pwrite;
    assign rd_en          = psel && !pwrite;
    assign addr_lo_unused = ^paddr[1:0];

    sysctl_store #(
        .IDX_W     (IDX_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (word_idx),
        .wr_data     (pwdata),
        .rd_idx      (word_idx),
        .rd_in_range (rd_in_range),
        .rd_word     (rd_word)
    );

    sysctl_rd_path #(
        .IDX_W (IDX_W)
    ) u_rd_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_idx      (word_idx),
        .rd_in_range (rd_in_range),
        .rd_word     (rd_word),
        .rdata       (prdata)
    );

    sysctl_cmd_decode #(
        .IDX_W   (IDX_W),
        .CMD_IDX (CMD_IDX)
    ) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_idx       (word_idx),
        .wr_data      (pwdata),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req)
    );

    AST_RESET_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(psel && pwrite && (paddr[ADDR_W-1:2] == IDX_W'(CMD_IDX))
                            && ((pwdata == 32'd1) || (pwdata == 32'd2)))); // R6
    AST_SHUTDOWN_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(psel && pwrite && (paddr[ADDR_W-1:2] == IDX_W'(CMD_IDX))
                               && (pwdata == 32'd3))); // R6
    AST_NO_PULSE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite) |=> !(reset_req || shutdown_req)); // R9

endmodule

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        reset_req;
    logic        shutdown_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model [512];

    always #10 clk = ~clk;

    sysctl_regbank u_sysctl_regbank (
        .clk          (clk),
        .rst_n        (rst_n),
        .psel         (psel),
        .pwrite       (pwrite),
        .paddr        (paddr),
        .pwdata       (pwdata),
        .prdata       (prdata),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        psel = 1'b0;
        d = prdata;
    endtask

    function automatic logic [31:0] expect_read(int unsigned idx);
        if (idx >= 512) return 32'h0;
        if (idx == 32'h40 || idx == 32'h42 || idx == 32'h43) return model[idx] | 32'h3000_0000;
        return model[idx];
    endfunction

    // R1: reset state
    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 512; i++) model[i] = 32'h0;
        model[32'h40] = 32'h05F2_0121;
        model[32'h41] = 32'h0000_0002;
        model[32'h42] = 32'h05F3_0121;
        model[32'h43] = 32'h05F4_0121;
        check("R1 reset_req idle", {31'b0, reset_req}, 32'h0);
        check("R1 shutdown_req idle", {31'b0, shutdown_req}, 32'h0);
        check("R1 prdata idle", prdata, 32'h0);
        bus_read(12'h100, d); check("R1 word 0x40", d, 32'h35F2_0121);
        bus_read(12'h104, d); check("R1 word 0x41", d, 32'h0000_0002);
        bus_read(12'h108, d); check("R1 word 0x42", d, 32'h35F3_0121);
        bus_read(12'h10C, d); check("R1 word 0x43", d, 32'h35F4_0121);
        for (int i = 0; i < 512; i++) begin
            bus_read(12'(i * 4), d);
            check("R1 reset sweep", d, expect_read(i));
        end
    endtask

    // R2: write and read back every backed word, read data holds
    task automatic t_full_range();
        logic [31:0] d;
        for (int i = 0; i < 512; i++) begin
            model[i] = 32'hA55A_0000 ^ (32'(i) * 32'h0001_0203);
            bus_write(12'(i * 4), model[i]);
        end
        for (int i = 0; i < 512; i++) begin
            bus_read(12'(i * 4), d);
            check("R2 readback", d, expect_read(i));
        end
        bus_read(12'h010, d);
        bus_write(12'h014, 32'hDEAD_BEEF);
        model[5] = 32'hDEAD_BEEF;
        check("R2 prdata holds over write", prdata, expect_read(4));
        @(negedge clk);
        check("R2 prdata holds idle", prdata, expect_read(4));
    endtask

    // R5: status flag merge
    task automatic t_status();
        logic [31:0] d;
        bus_write(12'h100, 32'h0); model[32'h40] = 32'h0;
        bus_read(12'h100, d); check("R5 0x100 flags on zero", d, 32'h3000_0000);
        bus_write(12'h108, 32'h0000_1234); model[32'h42] = 32'h0000_1234;
        bus_read(12'h108, d); check("R5 0x108 merged", d, 32'h3000_1234);
        bus_write(12'h10C, 32'hC000_0001); model[32'h43] = 32'hC000_0001;
        bus_read(12'h10C, d); check("R5 0x10C merged", d, 32'hF000_0001);
        bus_write(12'h104, 32'h0); model[32'h41] = 32'h0;
        bus_read(12'h104, d); check("R5 0x104 not forced", d, 32'h0);
        bus_write(12'h110, 32'h0); model[32'h44] = 32'h0;
        bus_read(12'h110, d); check("R5 0x110 not forced", d, 32'h0);
    endtask

    // R3, R4: upper half ignored for writes, zero on reads
    task automatic t_high();
        logic [31:0] d;
        for (int a = 32'h800; a < 32'h1000; a += 32'h40) begin
            if (a != 32'hF00) bus_write(12'(a), 32'hFFFF_FFFF);
        end
        bus_write(12'hFFC, 32'h1234_5678);
        bus_write(12'h800, 32'h8765_4321);
        for (int i = 0; i < 512; i++) begin
            bus_read(12'(i * 4), d);
            check("R3 backed word unchanged", d, expect_read(i));
        end
        bus_read(12'h800, d); check("R4 read 0x800", d, 32'h0);
        bus_read(12'hFFC, d); check("R4 read 0xFFC", d, 32'h0);
        bus_read(12'hA40, d); check("R4 read 0xA40", d, 32'h0);
    endtask

    // R6, R7, R9: command pulses
    task automatic t_commands();
        logic [31:0] d;
        for (int v = 0; v <= 4; v++) begin
            bus_write(12'hF00, 32'(v));
            check("R6 reset_req pulse", {31'b0, reset_req}, (v == 1 || v == 2) ? 32'h1 : 32'h0);
            check("R6 shutdown_req pulse", {31'b0, shutdown_req}, (v == 3) ? 32'h1 : 32'h0);
            @(negedge clk);
            check("R6 reset_req one cycle", {31'b0, reset_req}, 32'h0);
            check("R6 shutdown_req one cycle", {31'b0, shutdown_req}, 32'h0);
        end
        bus_read(12'hF00, d); check("R7 command not stored", d, 32'h0);
        for (int i = 0; i < 512; i += 37) begin
            bus_read(12'(i * 4), d);
            check("R7 backed words intact", d, expect_read(i));
        end
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = 12'hF00; pwdata = 32'd1;
        @(negedge clk);
        psel = 1'b0;
        check("R9 no reset pulse on read", {31'b0, reset_req}, 32'h0);
        check("R9 no shutdown pulse on read", {31'b0, shutdown_req}, 32'h0);
    endtask

    // R8: unaligned addresses select the containing word
    task automatic t_unaligned();
        logic [31:0] d;
        bus_write(12'h205, 32'h0BAD_F00D); model[32'h81] = 32'h0BAD_F00D;
        bus_read(12'h204, d); check("R8 unaligned write", d, 32'h0BAD_F00D);
        bus_read(12'h207, d); check("R8 unaligned read", d, 32'h0BAD_F00D);
        bus_read(12'h10A, d); check("R8 unaligned status", d, expect_read(32'h42));
        bus_write(12'hF03, 32'd3);
        check("R8 unaligned command", {31'b0, shutdown_req}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_range();
        t_status();
        t_high();
        t_commands();
        t_unaligned();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule